// File: doc/BRIEF.md
# Two-Hot Threshold Leak Strobe Generator

This block is a wide free-running cycle counter that produces periodic single-cycle leak pulses. Error-rate or credit leaky-bucket logic uses these pulses to drain its bucket. The counter has two sections. A hidden 11-bit prescaler advances on every clock. Its wrap carries into a 42-bit upper section that software can see.

Software sets the leak period with a two-hot threshold word: two bit positions of the upper section are marked. A period ends on the first cycle in which the registered upper count has every marked bit set. In that cycle the leak output pulses for one clock and the counter restarts. Because the test is a bitwise mask check, no magnitude comparator is needed. The upper count and the threshold are each split across a low and a high register. All four registers are reached through a simple synchronous write port and a combinational read port.

Top module: `leak_strobe_gen`

## Requirements
- R1: After synchronous reset, all four registers read zero and `leak` is low.
- R2: The hidden prescaler counts every cycle. The upper count advances by exactly one every 2048 cycles, and the prescaler cannot be read.
- R3: The register address encoding is: 0 = threshold bits 31:0, 1 = threshold bits 41:32, 2 = count bits 31:0, 3 = count bits 41:32. Both threshold halves read back the value written to them, limited to 10 bits in the high half.
- R4: In the two high-half registers (addresses 1 and 3), bits 9:0 hold data and bits 31:10 always read zero, even after a write of all ones.
- R5: When the threshold is nonzero and every threshold bit is set in the registered upper count, `leak` is high for exactly that one cycle.
- R6: In a match cycle, the upper count clears to zero and the prescaler restarts with the match cycle counted as tick zero. The leak-to-leak period is therefore 2048 × V cycles, where V is the smallest upper value that contains every marked bit.
- R7: An all-zero threshold disables leak generation. The upper count then wraps from all ones to zero.
- R8: A software write to a count half takes priority over both the hardware increment and the match clear for that half in the same cycle. The write does not disturb the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 32 | Register read data, combinational |
| leak | output | 1 | One-cycle leak pulse |

## Verification
The period check uses several thresholds. The directed mask marks the two lowest bits, and a seeded random draw selects pairs among the lower four bits. Each measured period must equal 2048 times the smallest matching value, which would expose an off-by-one in the restart or a match against the wrong bits. A threshold placed wholly in the high half, combined with a direct count write, checks the split match and the clear without a long wait. A zero threshold from a preloaded all-ones count separates the disabled case from a wrongly firing match. Writes timed onto a carry edge and onto a match edge test write priority, and a later increment shows that the prescaler phase survived the write.

// File: rtl/leak_pkg.sv
package leak_pkg;

  // Register address encoding shared by datapath and bench-visible map (R3)
  typedef enum logic [1:0] {
    ADDR_THR_LO = 2'd0,
    ADDR_THR_HI = 2'd1,
    ADDR_CNT_LO = 2'd2,
    ADDR_CNT_HI = 2'd3
  } regAddr_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic upInc;   // advance the upper section
    logic clrAll;  // end of period: clear upper, restart prescaler
    logic leak;    // pulse to the outside
  } leakCtrl_t;

endpackage

// File: rtl/leak_dp.sv
module leak_dp
  import leak_pkg::*;
#(
  parameter int PRE_W = 11,
  parameter int UP_W  = 42,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  input  leakCtrl_t        ctrl,
  output logic             preCarry,
  output logic [UP_W-1:0]  upCnt,
  output logic [UP_W-1:0]  thrWord,
  output logic [REG_W-1:0] rdData
);
  localparam int HI_W = UP_W - REG_W;
  localparam logic [PRE_W-1:0] PRE_MAX = '1;

  logic [PRE_W-1:0] preCnt;
  logic [REG_W-1:0] cntLo, thrLo;
  logic [HI_W-1:0]  cntHi, thrHi;
  logic [UP_W-1:0]  upNext;
  logic wrThrLo, wrThrHi, wrCntLo, wrCntHi;

  assign wrThrLo = wrEn && (wrAddr == ADDR_THR_LO);
  assign wrThrHi = wrEn && (wrAddr == ADDR_THR_HI);
  assign wrCntLo = wrEn && (wrAddr == ADDR_CNT_LO);
  assign wrCntHi = wrEn && (wrAddr == ADDR_CNT_HI);

  assign upCnt    = {cntHi, cntLo};
  assign thrWord  = {thrHi, thrLo};
  assign upNext   = upCnt + UP_W'(1);
  assign preCarry = (preCnt == PRE_MAX);

  // Hidden prescaler: the match cycle is tick zero of the next period
  always_ff @(posedge clk) begin
    if (rst)              preCnt <= '0;
    else if (ctrl.clrAll) preCnt <= PRE_W'(1);
    else                  preCnt <= preCnt + PRE_W'(1);
  end

  // Upper section, low half: software write wins over clear and increment
  always_ff @(posedge clk) begin
    if (rst)              cntLo <= '0;
    else if (wrCntLo)     cntLo <= wrData;
    else if (ctrl.clrAll) cntLo <= '0;
    else if (ctrl.upInc)  cntLo <= upNext[REG_W-1:0];
  end

  // Upper section, high half
  always_ff @(posedge clk) begin
    if (rst)              cntHi <= '0;
    else if (wrCntHi)     cntHi <= wrData[HI_W-1:0];
    else if (ctrl.clrAll) cntHi <= '0;
    else if (ctrl.upInc)  cntHi <= upNext[UP_W-1:REG_W];
  end

  // Threshold halves
  always_ff @(posedge clk) begin
    if (rst) begin
      thrLo <= '0;
      thrHi <= '0;
    end else begin
      if (wrThrLo) thrLo <= wrData;
      if (wrThrHi) thrHi <= wrData[HI_W-1:0];
    end
  end

  // Read mux, high halves zero-extended
  always_comb begin
    unique case (rdAddr)
      ADDR_THR_LO: rdData = thrLo;
      ADDR_THR_HI: rdData = REG_W'(thrHi);
      ADDR_CNT_LO: rdData = cntLo;
      default:     rdData = REG_W'(cntHi);
    endcase
  end

  // R2
  pre_advance_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.clrAll |=> preCnt == $past(preCnt) + PRE_W'(1));

  // R2
  up_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (preCnt != PRE_MAX) && !ctrl.clrAll && !wrCntLo && !wrCntHi |=> $stable(upCnt));

  // R6
  clr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.clrAll && !wrCntLo && !wrCntHi |=> (upCnt == '0) && (preCnt == PRE_W'(1)));

  // R8
  wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    wrCntLo |=> cntLo == $past(wrData));

endmodule

// File: rtl/leak_ctrl.sv
module leak_ctrl
  import leak_pkg::*;
#(
  parameter int UP_W = 42
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            preCarry,
  input  logic [UP_W-1:0] upCnt,
  input  logic [UP_W-1:0] thrWord,
  output leakCtrl_t       ctrl
);
  logic thrArmed, allMarked, hit;

  // Mask test on the registered count: no magnitude compare
  assign thrArmed  = |thrWord;
  assign allMarked = ((upCnt & thrWord) == thrWord);
  assign hit       = thrArmed && allMarked;

  always_comb begin
    ctrl.upInc  = preCarry;
    ctrl.clrAll = hit;
    ctrl.leak   = hit;
  end

  // R5
  leak_needs_bits_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.leak |-> ((upCnt | ~thrWord) == '1));

endmodule

// File: rtl/leak_strobe_gen.sv
module leak_strobe_gen
  import leak_pkg::*;
#(
  parameter int PRE_W = 11,
  parameter int UP_W  = 42,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [REG_W-1:0] rdData,
  output logic             leak
);
  localparam int HI_W = UP_W - REG_W;

  leakCtrl_t       ctrl;
  logic            preCarry;
  logic [UP_W-1:0] upCnt;
  logic [UP_W-1:0] thrWord;

  leak_dp #(.PRE_W(PRE_W), .UP_W(UP_W), .REG_W(REG_W)) dp_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .ctrl(ctrl), .preCarry(preCarry), .upCnt(upCnt),
    .thrWord(thrWord), .rdData(rdData)
  );

  leak_ctrl #(.UP_W(UP_W)) ctrl_i (
    .clk(clk), .rst(rst), .preCarry(preCarry), .upCnt(upCnt),
    .thrWord(thrWord), .ctrl(ctrl)
  );

  assign leak = ctrl.leak;

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rdAddr == ADDR_THR_HI || rdAddr == ADDR_CNT_HI) |-> rdData[REG_W-1:HI_W] == '0);

  // R5
  leak_single_chk: assert property (@(posedge clk) disable iff (rst)
    leak && !wrEn |=> !leak);

  // R7
  zero_thr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (thrWord == '0) |-> !leak);

endmodule

// File: tb/leak_strobe_gen_tb_top.sv
module leak_strobe_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = 2'd0;
  logic [31:0] rdData;
  logic        leak;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  leak_strobe_gen dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .leak(leak)
  );

  task automatic check(input string tag, input longint got, input longint exp);
    testCnt++;
    if (got != exp) begin
      failCnt++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  function automatic longint expPeriod(input logic [41:0] t);
    longint v = 1;
    while ((v & longint'(t)) != longint'(t)) v++;
    return v * 2048;
  endfunction

  task automatic setThr(input logic [41:0] t);
    regWrite(2'd0, t[31:0]);
    regWrite(2'd1, {22'd0, t[41:32]});
  endtask

  task automatic clearCnt();
    regWrite(2'd2, 32'd0);
    regWrite(2'd3, 32'd0);
  endtask

  task automatic waitLeak();
    while (!leak) @(negedge clk);
  endtask

  // R5 R6: period between consecutive leaks
  task automatic measurePeriod(input logic [41:0] t);
    longint n = 0;
    setThr(t);
    clearCnt();
    waitLeak();
    @(negedge clk);
    n = 1;
    while (!leak) begin
      @(negedge clk);
      n++;
    end
    check($sformatf("R6 period thr=0x%0h", t), n, expPeriod(t));
  endtask

  initial begin
    logic [31:0] rv;
    int unsigned seedVal = 32'd20240611;
    void'($urandom(seedVal));

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), rv);
      check($sformatf("R1 reset read addr %0d", a), rv, 0);
    end
    check("R1 leak low after reset", leak, 0);

    // R3 threshold readback, random data
    for (int i = 0; i < 3; i++) begin
      logic [31:0] d0 = $urandom;
      logic [31:0] d1 = $urandom;
      regWrite(2'd0, d0);
      regWrite(2'd1, d1);
      regRead(2'd0, rv); check("R3 thr low readback", rv, d0);
      regRead(2'd1, rv); check("R3 thr high readback", rv, {22'd0, d1[9:0]});
    end
    setThr('0);

    // R4 reserved bits of the high halves
    regWrite(2'd1, 32'hFFFF_FFFF);
    regRead(2'd1, rv); check("R4 thr high reserved zero", rv, 32'h3FF);
    regWrite(2'd1, 32'd0);
    regWrite(2'd3, 32'hFFFF_FFFF);
    regRead(2'd3, rv); check("R4 cnt high reserved zero", rv, 32'h3FF);

    // R7 zero threshold: wrap from all ones, no leak
    begin
      int leaks = 0;
      regWrite(2'd2, 32'hFFFF_FFFF);
      repeat (2048) begin
        @(negedge clk);
        if (leak) leaks++;
      end
      check("R7 no leak with zero threshold", leaks, 0);
      regRead(2'd2, rv); check("R7 wrap low half", rv, 0);
      regRead(2'd3, rv); check("R7 wrap high half", rv, 0);
    end

    // R2 one increment per 2048 cycles
    begin
      int k = $urandom_range(1, 3);
      clearCnt();
      repeat (k * 2048) @(negedge clk);
      regRead(2'd2, rv); check("R2 increments after k*2048 cycles", rv, k);
    end

    // R5 R6 directed and random periods
    measurePeriod(42'h3);
    for (int i = 0; i < 2; i++) begin
      int a = $urandom_range(0, 2);
      int b = $urandom_range(a + 1, 3);
      measurePeriod((42'd1 << a) | (42'd1 << b));
    end

    // R5 R6 threshold in the high half, match forced by a count write
    setThr(42'h3 << 32);
    regWrite(2'd2, 32'd0);
    regWrite(2'd3, 32'd3);
    check("R5 leak on high-half match", leak, 1);
    @(negedge clk);
    check("R5 leak lasts one cycle", leak, 0);
    regRead(2'd3, rv); check("R6 high half cleared", rv, 0);
    regRead(2'd2, rv); check("R6 low half cleared", rv, 0);

    // R8 write beats the match clear
    setThr(42'h3);
    clearCnt();
    waitLeak();
    wrEn = 1'b1; wrAddr = 2'd2; wrData = 32'd5;
    @(negedge clk);
    wrEn = 1'b0;
    regRead(2'd2, rv); check("R8 write over clear", rv, 5);
    check("R8 no leak after write", leak, 0);

    // R8 write beats the increment on a carry edge, prescaler undisturbed
    clearCnt();
    waitLeak();
    repeat (2047) @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd2; wrData = 32'h100;
    @(negedge clk);
    wrEn = 1'b0;
    regRead(2'd2, rv); check("R8 write over increment", rv, 32'h100);
    repeat (2047) @(negedge clk);
    regRead(2'd2, rv); check("R8 no increment before carry", rv, 32'h100);
    @(negedge clk);
    regRead(2'd2, rv); check("R8 prescaler phase kept", rv, 32'h101);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule